// File: doc/BRIEF.md
# Dot-Clock RGB Panel Timing Generator

This block drives a parallel RGB panel whose data bus is one byte wide. It divides the system clock down to a dot clock. From that dot clock it builds active-low line and frame sync, a data-enable strobe and the byte-wide data lane. Every 24-bit pixel leaves the block as three consecutive bytes, one per dot clock. With default parameters the active area is 320 pixels by 240 lines. Line timing is an 8-dot sync pulse, a 24-dot back porch and a 4-dot front porch. Frame timing is a 1-line sync pulse, a 3-line back porch and a 1-line front porch.

Pixels arrive on a valid/ready stream. The block does not buffer pixels. Ready is raised for exactly one system clock, in the cycle just before the dot-clock falling edge that launches a pixel's first byte. A pixel moves across the stream only when valid and ready are high in the same cycle, so the source may hold valid low for as long as it likes between pixels. If valid is low when ready is raised, the source has underflowed. The block then drops the rest of that frame, sets a sticky underflow flag and starts streaming again at the next frame.

The sync outputs run from the moment reset is released, whether or not any pixel data is flowing. Panel set-up code can therefore count frames using the one-cycle frame pulse. A video-enable input is sampled at every frame start and decides whether that frame carries pixel data.

Top module: `rgbt_dotclk_gen`

## Requirements
- R1: While reset is held, the outputs are as follows: the dot clock is low, line sync and frame sync are high, data-enable is low, data is 0, ready is low, the frame pulse is low and the underflow flag is clear.
- R2: The dot clock has a period of DIV system clocks and is high during the last DIV/2 of them. Sync, data-enable and data change only in the cycle where the dot clock falls.
- R3: A line lasts H_SYNC+H_BP+H_PIX*CPP+H_FP dot clocks. Line sync is low for the first H_SYNC dot clocks of every line.
- R4: A frame lasts V_SYNC+V_BP+V_LINES+V_FP lines. Frame sync is low for the first V_SYNC whole lines. It goes low on the same dot clock as the line sync of the frame's first line.
- R5: Data-enable is high only during a live frame. Within such a frame it covers dot clocks H_SYNC+H_BP through H_SYNC+H_BP+H_PIX*CPP-1 of lines V_SYNC+V_BP through V_SYNC+V_BP+V_LINES-1. In every other dot clock it is low and data is 0.
- R6: The bytes of a pixel leave the block on three consecutive dot clocks in the order bits 23:16, then 15:8, then 7:0.
- R7: Ready is high for one system clock per pixel, in the cycle before the falling dot-clock edge that launches the pixel's first byte, and at no other time. A pixel is taken when valid and ready are both high.
- R8: If valid is low while ready is high, the frame stops being live. Data-enable and ready then stay low until the end of that frame.
- R9: The underflow flag goes high in the cycle after an underflow. It stays high until the clear input is sampled high in a cycle with no new underflow.
- R10: The frame pulse is high for exactly one system clock, the cycle in which frame sync falls.
- R11: The video-enable input is sampled at each frame start. A frame that starts with it low has no data-enable and no ready, but its sync signals run as normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| video_en_i | input | 1 | Frame carries pixel data when high at frame start |
| pix_valid_i | input | 1 | Stream pixel valid |
| pix_data_i | input | PIX_W | Stream pixel, 24 bits by default |
| pix_ready_o | output | 1 | Stream pixel ready |
| uf_clr_i | input | 1 | Clears the underflow flag |
| dclk_o | output | 1 | Dot clock to the panel |
| hsync_n_o | output | 1 | Line sync, active low |
| vsync_n_o | output | 1 | Frame sync, active low |
| de_o | output | 1 | Data-enable |
| data_o | output | BUS_W | Byte lane to the panel |
| frame_o | output | 1 | One-cycle pulse on each falling edge of frame sync |
| uf_o | output | 1 | Sticky underflow flag |

## Verification
The first frames run with video-enable low. This separates the free-running sync from the data path: sync and frame pulses must appear with no data-enable and no ready at all. A frame with an unbroken pixel stream checks the full active window and the byte order against the bench model. A frame whose source stops partway through a middle active line must show the abandoned tail, the sticky flag, and then a clean restart once the flag is cleared. A later frame with video-enable dropped again shows that the enable is sampled only at frame boundaries.

// File: rtl/rgbt_pkg.sv
package rgbt_pkg;
  // Classification of the position a counter is about to show.
  typedef struct packed {
    logic in_sync;
    logic in_act;
  } seg_t;
endpackage

// File: rtl/rgbt_dclk_div.sv
module rgbt_dclk_div #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic step_o,
  output logic dclk_o
);
  localparam int W    = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int HALF = DIV / 2;
  localparam logic [W-1:0] LAST  = W'(DIV - 1);
  localparam logic [W-1:0] HIGHB = W'(HALF);

  logic [W-1:0] cnt_q, cnt_d;

  assign step_o = (cnt_q == LAST);
  assign cnt_d  = step_o ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      dclk_o <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      dclk_o <= (cnt_d >= HIGHB);
    end
  end
endmodule

// File: rtl/rgbt_seg_counter.sv
module rgbt_seg_counter
  import rgbt_pkg::*;
#(
  parameter int SYNC = 8,
  parameter int BP   = 24,
  parameter int ACT  = 960,
  parameter int FP   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  output seg_t upc_o,
  output logic wrap_o
);
  localparam int TOT = SYNC + BP + ACT + FP;
  localparam int W   = $clog2(TOT);
  localparam logic [W-1:0] LAST = W'(TOT - 1);
  localparam logic [W-1:0] S_END = W'(SYNC);
  localparam logic [W-1:0] A_BEG = W'(SYNC + BP);
  localparam logic [W-1:0] A_END = W'(SYNC + BP + ACT);

  logic [W-1:0] pos_q, upc;

  assign wrap_o = (pos_q == LAST);

  always_comb begin
    upc = pos_q;
    if (step_i) upc = wrap_o ? '0 : pos_q + 1'b1;
  end

  assign upc_o.in_sync = (upc < S_END);
  assign upc_o.in_act  = (upc >= A_BEG) && (upc < A_END);

  // Reset parks on the last position so the first step opens a new period.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= LAST;
    else        pos_q <= upc;
  end
endmodule

// File: rtl/rgbt_byte_ser.sv
module rgbt_byte_ser #(
  parameter int BUS_W = 8,
  parameter int CPP   = 3,
  localparam int PIX_W = BUS_W * CPP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             act_i,
  input  logic             live_i,
  input  logic             pix_valid_i,
  input  logic [PIX_W-1:0] pix_data_i,
  output logic             ready_o,
  output logic             starve_o,
  output logic             de_o,
  output logic [BUS_W-1:0] data_o
);
  localparam int SW = (CPP > 1) ? $clog2(CPP) : 1;
  localparam logic [SW-1:0] SLAST = SW'(CPP - 1);

  logic [SW-1:0]    sub_q;
  logic [PIX_W-1:0] sh_q;

  assign ready_o  = step_i && act_i && live_i && (sub_q == '0);
  assign starve_o = ready_o && !pix_valid_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q  <= '0;
      sh_q   <= '0;
      de_o   <= 1'b0;
      data_o <= '0;
    end else if (step_i) begin
      if (act_i && live_i) begin
        if (sub_q == '0) begin
          if (pix_valid_i) begin
            data_o <= pix_data_i[PIX_W-1 -: BUS_W];
            sh_q   <= pix_data_i << BUS_W;
            de_o   <= 1'b1;
            sub_q  <= (sub_q == SLAST) ? '0 : sub_q + 1'b1;
          end else begin
            data_o <= '0;
            de_o   <= 1'b0;
          end
        end else begin
          data_o <= sh_q[PIX_W-1 -: BUS_W];
          sh_q   <= sh_q << BUS_W;
          de_o   <= 1'b1;
          sub_q  <= (sub_q == SLAST) ? '0 : sub_q + 1'b1;
        end
      end else begin
        data_o <= '0;
        de_o   <= 1'b0;
        sub_q  <= '0;
      end
    end
  end

  // R7
  take_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o && pix_valid_i |=> de_o);
endmodule

// File: rtl/rgbt_dotclk_gen.sv
module rgbt_dotclk_gen
  import rgbt_pkg::*;
#(
  parameter int H_PIX   = 320,
  parameter int CPP     = 3,
  parameter int BUS_W   = 8,
  parameter int H_SYNC  = 8,
  parameter int H_BP    = 24,
  parameter int H_FP    = 4,
  parameter int V_LINES = 240,
  parameter int V_SYNC  = 1,
  parameter int V_BP    = 3,
  parameter int V_FP    = 1,
  parameter int DIV     = 2,
  localparam int PIX_W  = BUS_W * CPP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             video_en_i,
  input  logic             pix_valid_i,
  input  logic [PIX_W-1:0] pix_data_i,
  output logic             pix_ready_o,
  input  logic             uf_clr_i,
  output logic             dclk_o,
  output logic             hsync_n_o,
  output logic             vsync_n_o,
  output logic             de_o,
  output logic [BUS_W-1:0] data_o,
  output logic             frame_o,
  output logic             uf_o
);
  localparam int H_ACT = H_PIX * CPP;

  if (V_BP <= V_SYNC || H_BP <= H_SYNC || DIV < 2) begin : g_bad_timing
    $error("back porch must exceed sync width and DIV must be at least 2");
  end

  logic step, h_wrap, v_wrap, v_step, frame_start, starve, live_q;
  seg_t h_upc, v_upc;

  rgbt_dclk_div #(.DIV(DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .step_o(step), .dclk_o(dclk_o));

  assign v_step = step && h_wrap;

  rgbt_seg_counter #(.SYNC(H_SYNC), .BP(H_BP), .ACT(H_ACT), .FP(H_FP)) u_hcnt (
    .clk(clk), .rst_n(rst_n), .step_i(step), .upc_o(h_upc), .wrap_o(h_wrap));

  rgbt_seg_counter #(.SYNC(V_SYNC), .BP(V_BP), .ACT(V_LINES), .FP(V_FP)) u_vcnt (
    .clk(clk), .rst_n(rst_n), .step_i(v_step), .upc_o(v_upc), .wrap_o(v_wrap));

  assign frame_start = v_step && v_wrap;

  rgbt_byte_ser #(.BUS_W(BUS_W), .CPP(CPP)) u_ser (
    .clk(clk), .rst_n(rst_n), .step_i(step),
    .act_i(h_upc.in_act && v_upc.in_act), .live_i(live_q),
    .pix_valid_i(pix_valid_i), .pix_data_i(pix_data_i),
    .ready_o(pix_ready_o), .starve_o(starve),
    .de_o(de_o), .data_o(data_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsync_n_o <= 1'b1;
      vsync_n_o <= 1'b1;
      frame_o   <= 1'b0;
      live_q    <= 1'b0;
      uf_o      <= 1'b0;
    end else begin
      frame_o <= frame_start;
      if (step) begin
        hsync_n_o <= !h_upc.in_sync;
        vsync_n_o <= !v_upc.in_sync;
      end
      if (frame_start)  live_q <= video_en_i;
      else if (starve)  live_q <= 1'b0;
      if (starve)        uf_o <= 1'b1;
      else if (uf_clr_i) uf_o <= 1'b0;
    end
  end

  // R10
  frame_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_o |-> !vsync_n_o && $past(vsync_n_o));

  // R5
  de_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de_o |-> hsync_n_o && vsync_n_o);

  // R2
  data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(dclk_o) |-> $stable(data_o) && $stable(de_o) && $stable(hsync_n_o));

  // R8
  uf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready_o && !pix_valid_i |=> uf_o && !de_o);

  // R9
  uf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uf_o && !uf_clr_i |=> uf_o);

  // R7
  ready_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready_o |=> $fell(dclk_o));
endmodule

// File: tb/test_rgbt_dotclk_gen.sv
module test_rgbt_dotclk_gen;
  localparam int HP = 4, CPP = 3, HS = 2, HB = 3, HF = 2;
  localparam int VA = 3, VS = 1, VB = 2, VF = 1, DIV = 2;
  localparam int HT = HS + HB + HP * CPP + HF;
  localparam int VT = VS + VB + VA + VF;
  localparam int FULL_DE = HP * CPP * VA * DIV;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, valid = 1'b0, clr = 1'b0, gate = 1'b1;
  logic [23:0] pdata = '0;
  logic ready, dclk, hs_n, vs_n, de, frm, uf;
  logic [7:0] data;

  always #10 clk = ~clk;

  rgbt_dotclk_gen #(.H_PIX(HP), .CPP(CPP), .BUS_W(8), .H_SYNC(HS), .H_BP(HB),
    .H_FP(HF), .V_LINES(VA), .V_SYNC(VS), .V_BP(VB), .V_FP(VF), .DIV(DIV))
  i_rgbt_dotclk_gen (
    .clk(clk), .rst_n(rst_n), .video_en_i(en), .pix_valid_i(valid),
    .pix_data_i(pdata), .pix_ready_o(ready), .uf_clr_i(clr), .dclk_o(dclk),
    .hsync_n_o(hs_n), .vsync_n_o(vs_n), .de_o(de), .data_o(data),
    .frame_o(frm), .uf_o(uf));

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  logic [23:0] src_q[$];
  int next_pix = 24'h10203;
  int m_div = 0, m_h = HT - 1, m_v = VT - 1, m_sub = 0, m_frame = 0;
  bit m_live = 0, m_uf = 0;
  logic [23:0] m_pix;
  logic e_dclk = 0, e_hs = 1, e_vs = 1, e_de = 0, e_frm = 0;
  logic [7:0] e_data = 0;
  int nh, nv;
  bit st, rdy, starve;

  function automatic void upcoming(input bit s, output int h, output int v);
    h = m_h; v = m_v;
    if (s) begin
      h = (m_h == HT - 1) ? 0 : m_h + 1;
      if (m_h == HT - 1) v = (m_v == VT - 1) ? 0 : m_v + 1;
    end
  endfunction

  function automatic bit active(int h, int v);
    return h >= HS + HB && h < HS + HB + HP * CPP && v >= VS + VB && v < VS + VB + VA;
  endfunction

  function automatic bit exp_ready();
    int h, v;
    bit s = (m_div == DIV - 1);
    upcoming(s, h, v);
    return s && active(h, v) && m_live && m_sub == 0;
  endfunction

  always @(posedge clk) if (rst_n) begin
    st = (m_div == DIV - 1);
    rdy = exp_ready();
    starve = rdy && !valid;
    upcoming(st, nh, nv);
    e_frm = 0;
    if (st) begin
      if (nh == 0 && nv == 0) begin m_live = en; e_frm = 1; m_frame++; end
      e_hs = !(nh < HS);
      e_vs = !(nv < VS);
      if (active(nh, nv) && m_live) begin
        if (m_sub == 0) begin
          if (valid) begin
            m_pix = src_q.pop_front();
            e_data = m_pix[23:16]; e_de = 1; m_sub = 1;
          end else begin
            e_data = 0; e_de = 0; m_live = 0;
          end
        end else begin
          e_data = (m_sub == 1) ? m_pix[15:8] : m_pix[7:0];
          e_de = 1; m_sub = (m_sub + 1) % CPP;
        end
      end else begin
        e_de = 0; e_data = 0; m_sub = 0;
      end
      m_h = nh; m_v = nv;
    end
    m_div = st ? 0 : m_div + 1;
    e_dclk = (m_div >= DIV / 2);
    if (starve) m_uf = 1;
    else if (clr) m_uf = 0;
  end

  // ---------------- per-cycle comparison and statistics ----------------
  int de_cnt[8];
  int frm_cnt = 0, rdy_after_uf = 0, uf_seen = 0;

  always @(negedge clk) if (rst_n && !finished) begin
    chk("R2 dclk", dclk, e_dclk);
    chk("R3 hsync_n", hs_n, e_hs);
    chk("R4 vsync_n", vs_n, e_vs);
    chk("R5 de", de, e_de);
    chk("R6 data", data, e_data);
    chk("R7 ready", ready, exp_ready());
    chk("R9 uf", uf, m_uf);
    chk("R10 frame", frm, e_frm);
    if (m_frame < 8 && de) de_cnt[m_frame]++;
    if (frm) frm_cnt++;
    if (uf) uf_seen = 1;
    if (m_frame == 3 && uf && ready) rdy_after_uf++;
  end

  // pixel source: holds its front pixel until taken
  always @(negedge clk) begin
    while (src_q.size() < 8) begin
      src_q.push_back(24'(next_pix));
      next_pix = next_pix + 24'h030507;
    end
    valid <= gate && (src_q.size() > 0);
    pdata <= src_q[0];
  end

  task automatic finish_run();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 dclk", dclk, 0);   chk("R1 hsync_n", hs_n, 1);
    chk("R1 vsync_n", vs_n, 1); chk("R1 de", de, 0);
    chk("R1 data", data, 0);   chk("R1 ready", ready, 0);
    chk("R1 frame", frm, 0);   chk("R1 uf", uf, 0);
    rst_n = 1'b1;
    wait (m_frame == 1);
    @(negedge clk) en = 1'b1;          // frame 2 is live
    wait (m_frame == 3 && m_v == 4);
    @(negedge clk) gate = 1'b0;        // starve the stream mid-frame 3
    repeat (30) @(negedge clk);
    gate = 1'b1;
    wait (m_frame == 4);
    repeat (40) @(negedge clk);
    clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    repeat (20) @(negedge clk);
    en = 1'b0;                         // frame 5 without data
    wait (m_frame == 6);
    repeat (3) @(negedge clk);
    chk("R11 de in disabled frame 1", de_cnt[1], 0);
    chk("R5 de in full frame 2", de_cnt[2], FULL_DE);
    chk("R8 frame 3 truncated", (de_cnt[3] > 0 && de_cnt[3] < FULL_DE), 1);
    chk("R8 no ready after underflow", rdy_after_uf, 0);
    chk("R9 underflow flagged", uf_seen, 1);
    chk("R5 de in recovered frame 4", de_cnt[4], FULL_DE);
    chk("R11 de in disabled frame 5", de_cnt[5], 0);
    chk("R10 frame pulses", frm_cnt, 6);
    finish_run();
  end
endmodule